// File: doc/BRIEF.md
# Sixteen-of-twenty-five pulse swallower

This block thins an incoming stream of events so that exactly sixteen of every twenty-five reach its output. The output rate is 0.64 of the input rate, which is the same as dividing the rate by 1.5625. The nine events it removes in each group of twenty-five are spread across the group rather than removed in a single burst. Every input clock cycle in which the event strobe `ev_in` is high counts as one event. The block answers each event with a registered, one-cycle enable `en_out`, one cycle later, if that event survives. No clock is ever gated.

Two selectable implementations share the block, and `mode_sel` picks between them. The digit mode (`mode_sel`=0) tracks the position in the group as two base-5 digits and blocks by decoding them. The cascade mode (`mode_sel`=1) chains two stages, and each stage removes one event in five. Each digit or stage counter is a five-state machine with states DIG0, DIG1, DIG2, DIG3 and DIG4. The transitions are as follows:
- On an advance it steps DIGn→DIGn+1 and wraps DIG4→DIG0.
- Without an advance it holds its state.
- Synchronous reset forces it to DIG0.

In digit mode the high digit advances when the low digit wraps. In cascade mode the second stage advances only on events that the first stage passed.

Top module: `pulse_swallow_16of25`

## Requirements
- R1: Synchronous reset (`rst` high) clears `en_out` to 0 and returns every counter to DIG0. The first event after reset is position 0 of the group in either mode.
- R2: `en_out` is high in the cycle after a surviving event and low in the cycle after a cycle in which `ev_in` is low. A cycle with `ev_in` low does not move the position in the group.
- R3: In each mode, every 25 consecutive events from reset produce exactly 16 enables.
- R4: Digit mode (`mode_sel`=0) works on event position k in 0..24, with low digit lo = k mod 5 and high digit hi = k div 5. The event is blocked when lo is 1 or 3, except that hi=4 with lo=1 passes. The blocked positions are therefore 1, 3, 6, 8, 11, 13, 16, 18 and 23.
- R5: Cascade mode (`mode_sel`=1) has two stages:
  - Stage one counts every event modulo 5 and blocks the event seen at its count 4.
  - Stage two counts only the events that stage one passed, modulo 5, and blocks the one seen at its count 4.
  - The blocked positions are therefore 4, 5, 9, 11, 14, 17, 19, 23 and 24.
- R6: No run of consecutive blocked events is longer than 1 in digit mode or longer than 2 in cascade mode, including across the group boundary.
- R7: Only the selected implementation advances on an event. The other keeps its position, so switching modes resumes each one where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input event clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | 0 = base-5 digit decode, 1 = cascaded one-in-five stages |
| ev_in | input | 1 | High for one cycle per input event |
| en_out | output | 1 | Registered enable, high the cycle after a surviving event |

## Verification
The bench walks both modes with events arriving back to back and with idle gaps between them, and compares every enable against a position model. A design that counted idle cycles as events, or left the exemption at high digit 4 out of the decode, would pass 15 or 17 events per group; the window count and the per-position checks catch it. The bench also checks the boundary cases listed below.
- A reset in the middle of a group must restart at position 0. A design that kept the old position would block the wrong event.
- The double block at cascade positions 23, 24 must be followed by a pass at position 0. A second stage that counted blocked events would drift and produce a run of three.
- Switching modes must resume each path where it stopped. A path that advanced while deselected would shift its pattern.

// File: rtl/swal_pkg.sv
package swal_pkg;
    localparam int RADIX          = 5;
    localparam int DIG_W          = $clog2(RADIX);
    localparam int CYCLE_LEN      = RADIX * RADIX;
    localparam int PASS_PER_CYCLE = (RADIX - 1) * (RADIX - 1);
    localparam int POS_W          = $clog2(CYCLE_LEN);

    typedef enum logic [DIG_W-1:0] {
        DIG0 = 0,
        DIG1 = 1,
        DIG2 = 2,
        DIG3 = 3,
        DIG4 = 4
    } digit_e;
endpackage

// File: rtl/digit_fsm.sv
module digit_fsm
    import swal_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   adv,
    output digit_e dig
);
    digit_e cur, nxt;

    always_ff @(posedge clk) begin
        if (rst) cur <= DIG0;
        else     cur <= nxt;
    end

    always_comb begin
        nxt = cur;
        if (adv) begin
            unique case (cur)
                DIG0:    nxt = DIG1;
                DIG1:    nxt = DIG2;
                DIG2:    nxt = DIG3;
                DIG3:    nxt = DIG4;
                DIG4:    nxt = DIG0;
                default: nxt = DIG0;
            endcase
        end
    end

    assign dig = cur;

    a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cur));
endmodule

// File: rtl/base5_gate.sv
module base5_gate
    import swal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic pass
);
    digit_e lo, hi;
    logic   hi_adv;

    assign hi_adv = adv && (lo == DIG4);

    digit_fsm lo_i (.clk(clk), .rst(rst), .adv(adv),    .dig(lo));
    digit_fsm hi_i (.clk(clk), .rst(rst), .adv(hi_adv), .dig(hi));

    always_comb begin
        unique case (lo)
            DIG1:    pass = (hi == DIG4);
            DIG3:    pass = 1'b0;
            default: pass = 1'b1;
        endcase
    end

    // checker state
    logic             prev_blk;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] npass;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_blk <= 1'b0;
            pos      <= '0;
            npass    <= '0;
        end else if (adv) begin
            prev_blk <= !pass;
            pos      <= (pos == POS_W'(CYCLE_LEN - 1)) ? '0 : pos + POS_W'(1);
            npass    <= (pos == POS_W'(CYCLE_LEN - 1)) ? '0 : npass + POS_W'(pass);
        end
    end

    a_r6_single_block: assert property (@(posedge clk) disable iff (rst)
        adv && prev_blk |-> pass);
    a_r3_b5_sixteen: assert property (@(posedge clk) disable iff (rst)
        adv && (pos == POS_W'(CYCLE_LEN - 1)) |-> (npass + POS_W'(pass)) == POS_W'(PASS_PER_CYCLE));
    a_r4_top_exempt: assert property (@(posedge clk) disable iff (rst)
        adv && (pos == POS_W'(4 * RADIX + 1)) |-> pass);
endmodule

// File: rtl/cascade_gate.sv
module cascade_gate
    import swal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic pass
);
    digit_e s1, s2;
    logic   pass1, adv2;

    assign pass1 = (s1 != DIG4);
    assign adv2  = adv && pass1;
    assign pass  = pass1 && (s2 != DIG4);

    digit_fsm st1_i (.clk(clk), .rst(rst), .adv(adv),  .dig(s1));
    digit_fsm st2_i (.clk(clk), .rst(rst), .adv(adv2), .dig(s2));

    // checker state
    logic [1:0]       run;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] npass;

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= '0;
            pos   <= '0;
            npass <= '0;
        end else if (adv) begin
            run   <= pass ? 2'd0 : run + 2'd1;
            pos   <= (pos == POS_W'(CYCLE_LEN - 1)) ? '0 : pos + POS_W'(1);
            npass <= (pos == POS_W'(CYCLE_LEN - 1)) ? '0 : npass + POS_W'(pass);
        end
    end

    a_r6_cascade_run: assert property (@(posedge clk) disable iff (rst)
        adv && (run == 2'd2) |-> pass);
    a_r3_cs_sixteen: assert property (@(posedge clk) disable iff (rst)
        adv && (pos == POS_W'(CYCLE_LEN - 1)) |-> (npass + POS_W'(pass)) == POS_W'(PASS_PER_CYCLE));
    a_r5_stage2_hold: assert property (@(posedge clk) disable iff (rst)
        adv && !pass1 |=> $stable(s2));
endmodule

// File: rtl/pulse_swallow_16of25.sv
module pulse_swallow_16of25
    import swal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode_sel,
    input  logic ev_in,
    output logic en_out
);
    logic adv_b5, adv_cs;
    logic pass_b5, pass_cs, pass_sel;

    assign adv_b5 = ev_in && !mode_sel;
    assign adv_cs = ev_in &&  mode_sel;

    base5_gate   b5_i (.clk(clk), .rst(rst), .adv(adv_b5), .pass(pass_b5));
    cascade_gate cs_i (.clk(clk), .rst(rst), .adv(adv_cs), .pass(pass_cs));

    assign pass_sel = mode_sel ? pass_cs : pass_b5;

    always_ff @(posedge clk) begin
        if (rst) en_out <= 1'b0;
        else     en_out <= ev_in && pass_sel;
    end

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !ev_in |=> !en_out);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> !en_out);
endmodule

// File: tb/pulse_swallow_16of25_tb_top.sv
module pulse_swallow_16of25_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_sel = 1'b0;
    logic ev_in = 1'b0;
    logic en_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int kb5 = 0;
    int ca = 0;
    int cb = 0;

    pulse_swallow_16of25 dut_i (.clk(clk), .rst(rst), .mode_sel(mode_sel),
                                .ev_in(ev_in), .en_out(en_out));

    always #4 clk = ~clk;

    typedef struct packed {
        logic       mode;
        logic [1:0] gap;
    } row_t;

    localparam row_t TABLE [4] = '{
        '{mode: 1'b0, gap: 2'd0},
        '{mode: 1'b1, gap: 2'd0},
        '{mode: 1'b0, gap: 2'd2},
        '{mode: 1'b1, gap: 2'd1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_step(input bit mode, output bit p);
        if (!mode) begin
            int lo = kb5 % 5;
            int hi = kb5 / 5;
            p = ((lo % 2) == 0) || (hi == 4 && lo == 1);
            kb5 = (kb5 + 1) % 25;
        end else begin
            bit pa = (ca != 4);
            p = pa && (cb != 4);
            ca = (ca + 1) % 5;
            if (pa) cb = (cb + 1) % 5;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ev_in = 1'b1;
        repeat (3) @(negedge clk);
        check(en_out == 1'b0, "R1 reset clears output", en_out, 0);
        rst = 1'b0;
        ev_in = 1'b0;
        kb5 = 0; ca = 0; cb = 0;
        @(negedge clk);
        check(en_out == 1'b0, "R1 output low after reset", en_out, 0);
    endtask

    task automatic step(input bit ev, output bit got);
        ev_in = ev;
        @(negedge clk);
        got = en_out;
        ev_in = 1'b0;
    endtask

    task automatic event_check(input string req);
        bit exp, got;
        model_step(mode_sel, exp);
        step(1'b1, got);
        check(got == exp, req, got, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit got, exp;
        @(negedge clk);
        @(negedge clk);

        // table walk: R3 R4 R5 R6 and R2 idle gaps
        foreach (TABLE[i]) begin
            int win_cnt = 0;
            int run = 0;
            int limit;
            mode_sel = TABLE[i].mode;
            do_reset();
            limit = TABLE[i].mode ? 2 : 1;
            for (int n = 0; n < 50; n++) begin
                model_step(mode_sel, exp);
                step(1'b1, got);
                check(got == exp, mode_sel ? "R5 cascade position" : "R4 digit position", got, exp);
                win_cnt += got;
                run = got ? 0 : run + 1;
                check(run <= limit, "R6 blocked run length", run, limit);
                if ((n % 25) == 24) begin
                    check(win_cnt == 16, "R3 sixteen per 25", win_cnt, 16);
                    win_cnt = 0;
                end
                for (int g = 0; g < int'(TABLE[i].gap); g++) begin
                    step(1'b0, got);
                    check(got == 1'b0, "R2 idle gives no enable", got, 0);
                end
            end
        end

        // R1 mid-group reset restarts at position 0
        mode_sel = 1'b0;
        do_reset();
        for (int n = 0; n < 7; n++) step(1'b1, got);
        do_reset();
        step(1'b1, got);
        check(got == 1'b1, "R1 position 0 passes after reset", got, 1);
        step(1'b1, got);
        check(got == 1'b0, "R1 position 1 blocked after reset", got, 0);

        // R5 cascade double block at positions 4,5 then pass
        mode_sel = 1'b1;
        do_reset();
        for (int n = 0; n < 4; n++) begin
            step(1'b1, got);
            check(got == 1'b1, "R5 stage one passes 0..3", got, 1);
        end
        step(1'b1, got);
        check(got == 1'b0, "R5 stage one blocks position 4", got, 0);
        step(1'b1, got);
        check(got == 1'b0, "R5 stage two blocks position 5", got, 0);
        step(1'b1, got);
        check(got == 1'b1, "R6 pass after double block", got, 1);

        // R7 deselected path holds its position
        mode_sel = 1'b0;
        do_reset();
        for (int n = 0; n < 3; n++) event_check("R7 digit before switch");
        mode_sel = 1'b1;
        for (int n = 0; n < 4; n++) event_check("R7 cascade while digit held");
        mode_sel = 1'b0;
        step(1'b1, got);
        check(got == 1'b0, "R7 digit resumes at position 3", got, 0);
        kb5 = 4;
        event_check("R7 digit position 4");
        mode_sel = 1'b1;
        step(1'b1, got);
        check(got == 1'b0, "R7 cascade resumes at position 4", got, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule